// File: doc/BRIEF.md
# Memory Dependence Wakeup Tracker

This block sits beside the load/store issue logic of an out-of-order core. It keeps memory operations from issuing before the store they are predicted to depend on. Each load or store is inserted with its sequence number. The block asks an external dependence predictor which in-flight store, if any, the operation should wait for.

An operation becomes ready at once when no live producer is named. Otherwise it waits in that store's dependent list until the store's wakeup command releases it. The issue logic asks whether a sequence number is ready and tells the block when an operation issues. A squash drops every entry younger than a boundary. Stores, squashes and ordering violations are forwarded to the predictor so that it can keep its own tables in step.

The block accepts one command per cycle (insert, issue or wakeup) on a shared command port. A squash has a separate port and wins over any command in the same cycle. All state changes take effect at the clock edge that accepts them. Forwards and error pulses appear one cycle later.

Top module: `mdep_tracker`

## Requirements
- R1: The predictor query address `pq_pc` equals `ins_pc` in the same cycle. An accepted insert becomes ready when `pq_tag` is zero, or when no live store entry has sequence number `pq_tag`.
- R2: An accepted insert whose `pq_tag` names a live store entry becomes waiting. `qry_ready` stays low for it until that store is woken.
- R3: An accepted store insert (`ins_kind` = 2'b10) raises `pst_valid` with its address and sequence number one cycle later. A store insert whose sequence number already has a live store entry is rejected and pulses `err_dup` one cycle later.
- R4: `qry_ready` is high only for an operation that is present and ready. Issuing a ready operation removes it. Issuing one that is waiting or absent pulses `err_issue` one cycle later and changes nothing.
- R5: A wakeup on a store's sequence number turns its waiting dependents ready in insertion order and frees the store entry. A later insert naming that store becomes ready.
- R6: A wakeup on a sequence number with no live store entry changes no operation's state.
- R7: `ins_kind` 2'b01 is a load and 2'b10 is a store. Any other kind is rejected and pulses `err_kind` one cycle later.
- R8: A squash with boundary N removes every operation and store entry whose sequence number is greater than N. It drops dependents above N from surviving stores' lists, and raises `psq_valid`/`psq_seq` one cycle later.
- R9: An insert with no free operation slot, or a store with no free store slot, raises `ins_stall` and is not accepted. The same applies to an operation whose named store already holds the maximum number of dependents.
- R10: A squash in the same cycle as a command takes priority. The command is ignored, and an insert raises `ins_stall`.
- R11: An ordering violation is forwarded to the predictor one cycle later, with both the load address and the store address.
- R12: After reset no operation is ready, and no forward or error output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | Command: 0 none, 1 insert, 2 issue, 3 wakeup |
| cmd_seq | input | SEQ_W | Sequence number the command refers to |
| ins_kind | input | 2 | Operation kind on insert |
| ins_pc | input | PC_W | Instruction address on insert |
| ins_stall | output | 1 | Insert not accepted for lack of room or due to squash |
| pq_pc | output | PC_W | Address sent to the predictor |
| pq_tag | input | SEQ_W | Predicted producing store, zero for none |
| pst_valid | output | 1 | Store registration to predictor |
| pst_pc | output | PC_W | Registered store address |
| pst_seq | output | SEQ_W | Registered store sequence number |
| qry_seq | input | SEQ_W | Sequence number being asked about |
| qry_ready | output | 1 | That operation is ready to issue |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash boundary |
| psq_valid | output | 1 | Squash forwarded to predictor |
| psq_seq | output | SEQ_W | Forwarded squash boundary |
| viol_valid | input | 1 | Ordering violation detected |
| viol_ld_pc | input | PC_W | Violating load address |
| viol_st_pc | input | PC_W | Offending store address |
| pv_valid | output | 1 | Violation forwarded to predictor |
| pv_ld_pc | output | PC_W | Forwarded load address |
| pv_st_pc | output | PC_W | Forwarded store address |
| err_kind | output | 1 | Insert of an unknown kind |
| err_dup | output | 1 | Store inserted twice |
| err_issue | output | 1 | Issue of an operation that is not ready |

## Verification
The wakeup path is exercised with a store holding several waiting dependents. It is also tried with wakeups naming a load or an unknown number, and with a repeated wakeup. These separate a real release from a spurious one.

Sweeps fill the operation table, the store table and a single dependent list one entry at a time. This shows that the stall appears exactly at the entry after the last free one and never before it.

The squash pattern mixes ready entries, waiting entries and stores on both sides of the boundary. It then reuses squashed sequence numbers under a different producer. This tells strict-greater removal apart from greater-or-equal, and shows whether stale dependents are trimmed from surviving lists.

// File: rtl/mdep_pkg.sv
package mdep_pkg;
   typedef enum logic [1:0] {
      OP_NONE   = 2'd0,
      OP_INSERT = 2'd1,
      OP_ISSUE  = 2'd2,
      OP_WAKE   = 2'd3
   } mdep_op_e;

   localparam logic [1:0] KIND_LOAD  = 2'b01;
   localparam logic [1:0] KIND_STORE = 2'b10;
endpackage

// File: rtl/mdep_pick.sv
// Picks one set bit out of a request vector; direction chosen by parameter.
module mdep_pick #(
   parameter int N         = 16,
   parameter bit LOW_FIRST = 1'b1,
   localparam int IW       = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   assign any = |req;

   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req[i]) idx = IW'(i);
            end
         end
      end else begin : g_high
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++) begin
               if (req[i]) idx = IW'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mdep_op_table.sv
// Operation slots: each holds a sequence number and a waiting/ready state.
module mdep_op_table #(
   parameter int SEQ_W     = 16,
   parameter int N_OPS     = 16,
   parameter int N_DEP     = 4,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [SEQ_W-1:0]             qry_seq,
   output logic                         qry_ready,
   input  logic [SEQ_W-1:0]             iss_seq,
   output logic                         iss_ok,
   input  logic [N_DEP-1:0][SEQ_W-1:0]  chk_seq,
   output logic [N_DEP-1:0]             chk_wait,
   output logic                         has_free,
   input  logic                         alloc_en,
   input  logic [SEQ_W-1:0]             alloc_seq,
   input  logic                         alloc_wait,
   input  logic                         iss_en,
   input  logic [N_DEP-1:0]             wake_mask,
   input  logic                         sq_en,
   input  logic [SEQ_W-1:0]             sq_seq
);
   localparam int IW = (N_OPS > 1) ? $clog2(N_OPS) : 1;

   logic [N_OPS-1:0] vld_q;
   logic [N_OPS-1:0] wait_q;
   logic [SEQ_W-1:0] seq_q [N_OPS];

   logic [N_OPS-1:0] free_vec;
   logic [N_OPS-1:0] qry_vec;
   logic [N_OPS-1:0] iss_vec;
   logic [IW-1:0]    free_idx;

   always_comb begin
      for (int i = 0; i < N_OPS; i++) begin
         free_vec[i] = !vld_q[i];
         qry_vec[i]  = vld_q[i] && !wait_q[i] && (seq_q[i] == qry_seq);
         iss_vec[i]  = vld_q[i] && !wait_q[i] && (seq_q[i] == iss_seq);
      end
   end

   always_comb begin
      for (int d = 0; d < N_DEP; d++) begin
         chk_wait[d] = 1'b0;
         for (int i = 0; i < N_OPS; i++) begin
            if (vld_q[i] && wait_q[i] && (seq_q[i] == chk_seq[d]))
               chk_wait[d] = 1'b1;
         end
      end
   end

   assign qry_ready = |qry_vec;
   assign iss_ok    = |iss_vec;

   mdep_pick #(.N(N_OPS), .LOW_FIRST(LOW_FIRST)) u_free (
      .req (free_vec),
      .any (has_free),
      .idx (free_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= '0;
         wait_q <= '0;
         for (int i = 0; i < N_OPS; i++) seq_q[i] <= '0;
      end else if (sq_en) begin
         for (int i = 0; i < N_OPS; i++) begin
            if (vld_q[i] && (seq_q[i] > sq_seq)) vld_q[i] <= 1'b0;
         end
      end else begin
         if (alloc_en) begin
            vld_q[free_idx]  <= 1'b1;
            wait_q[free_idx] <= alloc_wait;
            seq_q[free_idx]  <= alloc_seq;
         end
         for (int i = 0; i < N_OPS; i++) begin
            if (iss_en && iss_vec[i]) vld_q[i] <= 1'b0;
            for (int d = 0; d < N_DEP; d++) begin
               if (wake_mask[d] && vld_q[i] && wait_q[i] && (seq_q[i] == chk_seq[d]))
                  wait_q[i] <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/mdep_store_table.sv
// Store slots: each holds a store sequence number and its ordered dependent list.
module mdep_store_table #(
   parameter int SEQ_W     = 16,
   parameter int N_ST      = 8,
   parameter int N_DEP     = 4,
   parameter bit LOW_FIRST = 1'b1,
   localparam int CW       = $clog2(N_DEP + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [SEQ_W-1:0]             prod_seq,
   output logic                         prod_hit,
   output logic                         prod_full,
   input  logic [SEQ_W-1:0]             dup_seq,
   output logic                         dup_hit,
   input  logic [SEQ_W-1:0]             wk_seq,
   output logic                         wk_hit,
   output logic [N_DEP-1:0][SEQ_W-1:0]  wk_deps,
   output logic [CW-1:0]                wk_cnt,
   output logic                         has_free,
   input  logic                         alloc_en,
   input  logic [SEQ_W-1:0]             alloc_seq,
   input  logic                         app_en,
   input  logic [SEQ_W-1:0]             app_seq,
   input  logic                         rel_en,
   input  logic                         sq_en,
   input  logic [SEQ_W-1:0]             sq_seq
);
   localparam int IW = (N_ST > 1) ? $clog2(N_ST) : 1;

   logic [N_ST-1:0]             vld_q;
   logic [SEQ_W-1:0]            seq_q [N_ST];
   logic [CW-1:0]               cnt_q [N_ST];
   logic [N_DEP-1:0][SEQ_W-1:0] dep_q [N_ST];

   logic [N_ST-1:0] free_vec, prod_vec, dup_vec, wk_vec;
   logic [IW-1:0]   free_idx, prod_idx, wk_idx;
   logic [CW-1:0]   keep_cnt [N_ST];

   always_comb begin
      for (int j = 0; j < N_ST; j++) begin
         free_vec[j] = !vld_q[j];
         prod_vec[j] = vld_q[j] && (seq_q[j] == prod_seq);
         dup_vec[j]  = vld_q[j] && (seq_q[j] == dup_seq);
         wk_vec[j]   = vld_q[j] && (seq_q[j] == wk_seq);
      end
   end

   mdep_pick #(.N(N_ST), .LOW_FIRST(LOW_FIRST)) u_free (
      .req (free_vec), .any (has_free), .idx (free_idx));
   mdep_pick #(.N(N_ST), .LOW_FIRST(LOW_FIRST)) u_prod (
      .req (prod_vec), .any (prod_hit), .idx (prod_idx));
   mdep_pick #(.N(N_ST), .LOW_FIRST(LOW_FIRST)) u_wake (
      .req (wk_vec), .any (wk_hit), .idx (wk_idx));

   assign dup_hit   = |dup_vec;
   assign prod_full = prod_hit && (cnt_q[prod_idx] == CW'(N_DEP));
   assign wk_deps   = dep_q[wk_idx];
   assign wk_cnt    = wk_hit ? cnt_q[wk_idx] : '0;

   // Dependents are appended in ascending sequence order, so the survivors
   // of a squash form a prefix of each list.
   always_comb begin
      for (int j = 0; j < N_ST; j++) begin
         keep_cnt[j] = '0;
         for (int d = 0; d < N_DEP; d++) begin
            if ((CW'(d) < cnt_q[j]) && (dep_q[j][d] <= sq_seq))
               keep_cnt[j] = keep_cnt[j] + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int j = 0; j < N_ST; j++) begin
            seq_q[j] <= '0;
            cnt_q[j] <= '0;
            dep_q[j] <= '0;
         end
      end else if (sq_en) begin
         for (int j = 0; j < N_ST; j++) begin
            if (vld_q[j] && (seq_q[j] > sq_seq)) vld_q[j] <= 1'b0;
            cnt_q[j] <= keep_cnt[j];
         end
      end else begin
         if (alloc_en) begin
            vld_q[free_idx] <= 1'b1;
            seq_q[free_idx] <= alloc_seq;
            cnt_q[free_idx] <= '0;
         end
         if (app_en) begin
            for (int d = 0; d < N_DEP; d++) begin
               if (CW'(d) == cnt_q[prod_idx]) dep_q[prod_idx][d] <= app_seq;
            end
            cnt_q[prod_idx] <= cnt_q[prod_idx] + 1'b1;
         end
         if (rel_en) vld_q[wk_idx] <= 1'b0;
      end
   end
endmodule

// File: rtl/mdep_tracker.sv
module mdep_tracker
   import mdep_pkg::*;
#(
   parameter int SEQ_W     = 16,
   parameter int PC_W      = 32,
   parameter int N_OPS     = 16,
   parameter int N_ST      = 8,
   parameter int N_DEP     = 4,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cmd_op,
   input  logic [SEQ_W-1:0] cmd_seq,
   input  logic [1:0]       ins_kind,
   input  logic [PC_W-1:0]  ins_pc,
   output logic             ins_stall,
   output logic [PC_W-1:0]  pq_pc,
   input  logic [SEQ_W-1:0] pq_tag,
   output logic             pst_valid,
   output logic [PC_W-1:0]  pst_pc,
   output logic [SEQ_W-1:0] pst_seq,
   input  logic [SEQ_W-1:0] qry_seq,
   output logic             qry_ready,
   input  logic             sq_valid,
   input  logic [SEQ_W-1:0] sq_seq,
   output logic             psq_valid,
   output logic [SEQ_W-1:0] psq_seq,
   input  logic             viol_valid,
   input  logic [PC_W-1:0]  viol_ld_pc,
   input  logic [PC_W-1:0]  viol_st_pc,
   output logic             pv_valid,
   output logic [PC_W-1:0]  pv_ld_pc,
   output logic [PC_W-1:0]  pv_st_pc,
   output logic             err_kind,
   output logic             err_dup,
   output logic             err_issue
);
   localparam int CW = $clog2(N_DEP + 1);

   generate
      if (SEQ_W < 2)         begin : g_bad_seq $error("SEQ_W must be at least 2"); end
      if (N_OPS < 2)         begin : g_bad_ops $error("N_OPS must be at least 2"); end
      if (N_ST < 1)          begin : g_bad_st  $error("N_ST must be at least 1"); end
      if (N_ST > N_OPS)      begin : g_bad_mix $error("N_ST may not exceed N_OPS"); end
      if (N_DEP < 1)         begin : g_bad_dep $error("N_DEP must be at least 1"); end
   endgenerate

   // Command decode; a squash masks every command in its cycle.
   logic do_ins, do_iss, do_wk_cmd;
   logic is_ld, is_st, kind_ok;
   assign do_ins    = (cmd_op == OP_INSERT) && !sq_valid;
   assign do_iss    = (cmd_op == OP_ISSUE)  && !sq_valid;
   assign do_wk_cmd = (cmd_op == OP_WAKE)   && !sq_valid;
   assign is_ld     = (ins_kind == KIND_LOAD);
   assign is_st     = (ins_kind == KIND_STORE);
   assign kind_ok   = is_ld || is_st;

   assign pq_pc = ins_pc;

   // Table interconnect
   logic                        op_free, st_free;
   logic                        prod_hit, prod_full, dup_hit;
   logic                        iss_ok;
   logic                        wk_hit;
   logic [N_DEP-1:0][SEQ_W-1:0] wk_deps;
   logic [CW-1:0]               wk_cnt;
   logic [N_DEP-1:0]            dep_wait;
   logic [N_DEP-1:0]            wake_mask;

   logic tag_live, dup_bad, no_room, accept, do_wk;
   assign tag_live  = (pq_tag != '0) && prod_hit;
   assign dup_bad   = is_st && dup_hit;
   assign no_room   = !op_free || (is_st && !st_free) || (tag_live && prod_full);
   assign accept    = do_ins && kind_ok && !dup_bad && !no_room;
   assign ins_stall = (cmd_op == OP_INSERT) &&
                      (sq_valid || (kind_ok && !dup_bad && no_room));
   assign do_wk     = do_wk_cmd && wk_hit;

   // Release dependents in list order, stopping at the first one that is
   // no longer waiting.
   always_comb begin
      logic run;
      run = 1'b1;
      for (int d = 0; d < N_DEP; d++) begin
         run          = run && (CW'(d) < wk_cnt) && dep_wait[d];
         wake_mask[d] = do_wk && run;
      end
   end

   mdep_op_table #(
      .SEQ_W(SEQ_W), .N_OPS(N_OPS), .N_DEP(N_DEP), .LOW_FIRST(LOW_FIRST)
   ) u_ops (
      .clk        (clk),
      .rst_n      (rst_n),
      .qry_seq    (qry_seq),
      .qry_ready  (qry_ready),
      .iss_seq    (cmd_seq),
      .iss_ok     (iss_ok),
      .chk_seq    (wk_deps),
      .chk_wait   (dep_wait),
      .has_free   (op_free),
      .alloc_en   (accept),
      .alloc_seq  (cmd_seq),
      .alloc_wait (tag_live),
      .iss_en     (do_iss && iss_ok),
      .wake_mask  (wake_mask),
      .sq_en      (sq_valid),
      .sq_seq     (sq_seq)
   );

   mdep_store_table #(
      .SEQ_W(SEQ_W), .N_ST(N_ST), .N_DEP(N_DEP), .LOW_FIRST(LOW_FIRST)
   ) u_stores (
      .clk       (clk),
      .rst_n     (rst_n),
      .prod_seq  (pq_tag),
      .prod_hit  (prod_hit),
      .prod_full (prod_full),
      .dup_seq   (cmd_seq),
      .dup_hit   (dup_hit),
      .wk_seq    (cmd_seq),
      .wk_hit    (wk_hit),
      .wk_deps   (wk_deps),
      .wk_cnt    (wk_cnt),
      .has_free  (st_free),
      .alloc_en  (accept && is_st),
      .alloc_seq (cmd_seq),
      .app_en    (accept && tag_live),
      .app_seq   (cmd_seq),
      .rel_en    (do_wk),
      .sq_en     (sq_valid),
      .sq_seq    (sq_seq)
   );

   // Registered forwards and error pulses
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pst_valid <= 1'b0;
         pst_pc    <= '0;
         pst_seq   <= '0;
         psq_valid <= 1'b0;
         psq_seq   <= '0;
         pv_valid  <= 1'b0;
         pv_ld_pc  <= '0;
         pv_st_pc  <= '0;
         err_kind  <= 1'b0;
         err_dup   <= 1'b0;
         err_issue <= 1'b0;
      end else begin
         pst_valid <= accept && is_st;
         pst_pc    <= ins_pc;
         pst_seq   <= cmd_seq;
         psq_valid <= sq_valid;
         psq_seq   <= sq_seq;
         pv_valid  <= viol_valid;
         pv_ld_pc  <= viol_ld_pc;
         pv_st_pc  <= viol_st_pc;
         err_kind  <= do_ins && !kind_ok;
         err_dup   <= do_ins && dup_bad;
         err_issue <= do_iss && !iss_ok;
      end
   end
endmodule

// File: rtl/mdep_tracker_chk.sv
module mdep_tracker_chk
   import mdep_pkg::*;
#(
   parameter int SEQ_W = 16,
   parameter int PC_W  = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       cmd_op,
   input logic [1:0]       ins_kind,
   input logic             ins_stall,
   input logic             pst_valid,
   input logic             sq_valid,
   input logic [SEQ_W-1:0] sq_seq,
   input logic             psq_valid,
   input logic [SEQ_W-1:0] psq_seq,
   input logic             viol_valid,
   input logic [PC_W-1:0]  viol_ld_pc,
   input logic [PC_W-1:0]  viol_st_pc,
   input logic             pv_valid,
   input logic [PC_W-1:0]  pv_ld_pc,
   input logic [PC_W-1:0]  pv_st_pc,
   input logic             err_kind,
   input logic             err_dup,
   input logic             err_issue
);
   assert_sq_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_valid && cmd_op == OP_INSERT) |-> ins_stall);

   assert_sq_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sq_valid |=> (psq_valid && psq_seq == $past(sq_seq)));

   assert_viol_forward_R11: assert property (@(posedge clk) disable iff (!rst_n)
      viol_valid |=> (pv_valid && pv_ld_pc == $past(viol_ld_pc) && pv_st_pc == $past(viol_st_pc)));

   assert_stall_rejects_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == OP_INSERT && ins_stall) |=> (!pst_valid && !err_kind && !err_dup));

   assert_err_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_kind, err_dup, err_issue}));

   assert_bad_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == OP_INSERT && !sq_valid && ins_kind != KIND_LOAD && ins_kind != KIND_STORE)
      |=> (err_kind && !pst_valid));

   assert_store_reg_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pst_valid) |-> $past(cmd_op == OP_INSERT && ins_kind == KIND_STORE && !sq_valid));

   assert_issue_err_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_issue) |-> $past(cmd_op == OP_ISSUE && !sq_valid));
endmodule

bind mdep_tracker mdep_tracker_chk #(.SEQ_W(SEQ_W), .PC_W(PC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_op     (cmd_op),
   .ins_kind   (ins_kind),
   .ins_stall  (ins_stall),
   .pst_valid  (pst_valid),
   .sq_valid   (sq_valid),
   .sq_seq     (sq_seq),
   .psq_valid  (psq_valid),
   .psq_seq    (psq_seq),
   .viol_valid (viol_valid),
   .viol_ld_pc (viol_ld_pc),
   .viol_st_pc (viol_st_pc),
   .pv_valid   (pv_valid),
   .pv_ld_pc   (pv_ld_pc),
   .pv_st_pc   (pv_st_pc),
   .err_kind   (err_kind),
   .err_dup    (err_dup),
   .err_issue  (err_issue)
);

// File: tb/mdep_tracker_bench.sv
module mdep_tracker_bench;
   localparam int SW = 16;
   localparam int PW = 32;
   localparam int NO = 16;
   localparam int NS = 8;
   localparam int ND = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cmd_op = 2'd0;
   logic [SW-1:0] cmd_seq = '0;
   logic [1:0]    ins_kind = 2'b00;
   logic [PW-1:0] ins_pc = '0;
   logic          ins_stall;
   logic [PW-1:0] pq_pc;
   logic [SW-1:0] pq_tag = '0;
   logic          pst_valid;
   logic [PW-1:0] pst_pc;
   logic [SW-1:0] pst_seq;
   logic [SW-1:0] qry_seq = '0;
   logic          qry_ready;
   logic          sq_valid = 1'b0;
   logic [SW-1:0] sq_seq = '0;
   logic          psq_valid;
   logic [SW-1:0] psq_seq;
   logic          viol_valid = 1'b0;
   logic [PW-1:0] viol_ld_pc = '0;
   logic [PW-1:0] viol_st_pc = '0;
   logic          pv_valid;
   logic [PW-1:0] pv_ld_pc;
   logic [PW-1:0] pv_st_pc;
   logic          err_kind, err_dup, err_issue;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mdep_tracker u_mdep_tracker (
      .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_seq(cmd_seq),
      .ins_kind(ins_kind), .ins_pc(ins_pc), .ins_stall(ins_stall),
      .pq_pc(pq_pc), .pq_tag(pq_tag), .pst_valid(pst_valid),
      .pst_pc(pst_pc), .pst_seq(pst_seq), .qry_seq(qry_seq),
      .qry_ready(qry_ready), .sq_valid(sq_valid), .sq_seq(sq_seq),
      .psq_valid(psq_valid), .psq_seq(psq_seq), .viol_valid(viol_valid),
      .viol_ld_pc(viol_ld_pc), .viol_st_pc(viol_st_pc), .pv_valid(pv_valid),
      .pv_ld_pc(pv_ld_pc), .pv_st_pc(pv_st_pc), .err_kind(err_kind),
      .err_dup(err_dup), .err_issue(err_issue)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One command per call; returns at posedge+1 with registered outputs visible.
   task automatic cmd(input logic [1:0] op, input logic [1:0] kind, input int seq,
                      input int tag, input int pc, output logic stall, output logic [PW-1:0] qpc);
      @(negedge clk);
      cmd_op = op; ins_kind = kind; cmd_seq = SW'(seq); pq_tag = SW'(tag); ins_pc = PW'(pc);
      #1;
      stall = ins_stall;
      qpc   = pq_pc;
      @(posedge clk);
      #1;
      cmd_op = 2'd0;
   endtask

   task automatic ins(input logic [1:0] kind, input int seq, input int tag, output logic stall);
      logic [PW-1:0] qpc;
      cmd(2'd1, kind, seq, tag, 32'h1000 + seq * 4, stall, qpc);
   endtask

   task automatic issue(input int seq);
      logic s; logic [PW-1:0] q;
      cmd(2'd2, 2'b00, seq, 0, 0, s, q);
   endtask

   task automatic wake(input int seq);
      logic s; logic [PW-1:0] q;
      cmd(2'd3, 2'b00, seq, 0, 0, s, q);
   endtask

   task automatic squash(input int n);
      @(negedge clk);
      sq_valid = 1'b1; sq_seq = SW'(n);
      @(posedge clk);
      #1;
      sq_valid = 1'b0;
      check("R8 squash forward valid", 64'(psq_valid), 64'd1);
      check("R8 squash forward boundary", 64'(psq_seq), 64'(n));
   endtask

   task automatic rdy(input string req, input int seq, input logic exp);
      qry_seq = SW'(seq);
      #1;
      check(req, 64'(qry_ready), 64'(exp));
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic st;
      logic [PW-1:0] qpc;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R12: reset state
      rdy("R12 nothing ready after reset", 0, 1'b0);
      check("R12 no store forward", 64'(pst_valid), 64'd0);
      check("R12 no errors", 64'({err_kind, err_dup, err_issue, psq_valid, pv_valid}), 64'd0);

      // R1: no predicted producer, and a producer that is not live
      cmd(2'd1, 2'b01, 5, 0, 32'hABCD0, st, qpc);
      check("R1 predictor query address", 64'(qpc), 64'h000ABCD0);
      check("R1 insert accepted", 64'(st), 64'd0);
      rdy("R1 tag zero goes ready", 5, 1'b1);
      ins(2'b01, 6, 99, st);
      rdy("R1 dead producer goes ready", 6, 1'b1);

      // R3: store registration
      ins(2'b10, 10, 0, st);
      check("R3 store forward valid", 64'(pst_valid), 64'd1);
      check("R3 store forward seq", 64'(pst_seq), 64'd10);
      check("R3 store forward pc", 64'(pst_pc), 64'h1000 + 40);
      rdy("R1 store with no producer ready", 10, 1'b1);

      // R2: dependents wait
      ins(2'b01, 11, 10, st);
      ins(2'b01, 12, 10, st);
      ins(2'b10, 13, 10, st);
      rdy("R2 load 11 waits", 11, 1'b0);
      rdy("R2 load 12 waits", 12, 1'b0);
      rdy("R2 store 13 waits", 13, 1'b0);

      // R3: duplicate store
      ins(2'b10, 10, 0, st);
      check("R3 duplicate store flagged", 64'(err_dup), 64'd1);
      check("R3 duplicate not registered", 64'(pst_valid), 64'd0);

      // R4: issuing a waiting op is an error and changes nothing
      issue(12);
      check("R4 issue of waiting op flagged", 64'(err_issue), 64'd1);
      rdy("R4 waiting op untouched", 12, 1'b0);

      // R5: wakeup
      wake(10);
      rdy("R5 dependent 11 released", 11, 1'b1);
      rdy("R5 dependent 12 released", 12, 1'b1);
      rdy("R5 dependent 13 released", 13, 1'b1);
      ins(2'b01, 14, 10, st);
      rdy("R5 freed store no longer holds", 14, 1'b1);

      // R4: issue and re-issue
      issue(11);
      check("R4 issue of ready op ok", 64'(err_issue), 64'd0);
      rdy("R4 issued op gone", 11, 1'b0);
      issue(11);
      check("R4 second issue flagged", 64'(err_issue), 64'd1);

      // R6: wakeup with no store entry
      ins(2'b10, 50, 0, st);
      ins(2'b01, 51, 50, st);
      wake(52);
      rdy("R6 unknown wakeup leaves waiter", 51, 1'b0);
      wake(12);
      rdy("R6 wakeup on a load leaves waiter", 51, 1'b0);
      rdy("R6 wakeup on a load keeps it ready", 12, 1'b1);
      wake(50);
      rdy("R5 waiter released by its store", 51, 1'b1);

      // R7: bad kinds
      for (int k = 0; k < 4; k += 3) begin
         ins(2'(k), 60 + k, 0, st);
         check("R7 bad kind flagged", 64'(err_kind), 64'd1);
         rdy("R7 bad kind not inserted", 60 + k, 1'b0);
      end

      // R11: violation forward
      @(negedge clk);
      viol_valid = 1'b1; viol_ld_pc = 32'h4444; viol_st_pc = 32'h8888;
      @(posedge clk);
      #1 viol_valid = 1'b0;
      check("R11 violation valid", 64'(pv_valid), 64'd1);
      check("R11 violation addresses", 64'({pv_ld_pc, pv_st_pc}), {32'h4444, 32'h8888});

      // R8: squash boundary
      squash(0);
      rdy("R8 squash 0 clears everything", 12, 1'b0);
      ins(2'b10, 20, 0, st);
      ins(2'b01, 21, 20, st);
      ins(2'b01, 22, 20, st);
      ins(2'b01, 25, 0, st);
      ins(2'b10, 30, 0, st);
      squash(21);
      rdy("R8 younger ready op removed", 25, 1'b0);
      rdy("R8 boundary op survives waiting", 21, 1'b0);
      ins(2'b01, 31, 30, st);
      rdy("R8 younger store entry removed", 31, 1'b1);
      ins(2'b10, 23, 0, st);
      ins(2'b01, 22, 23, st);
      wake(20);
      rdy("R8 surviving dependent released", 21, 1'b1);
      rdy("R8 trimmed dependent stays waiting", 22, 1'b0);
      wake(23);
      rdy("R8 reused number released by new store", 22, 1'b1);

      // R10: squash wins over insert
      @(negedge clk);
      sq_valid = 1'b1; sq_seq = SW'(1000);
      cmd_op = 2'd1; ins_kind = 2'b01; cmd_seq = SW'(600); pq_tag = '0;
      #1 check("R10 insert stalled by squash", 64'(ins_stall), 64'd1);
      @(posedge clk);
      #1 begin sq_valid = 1'b0; cmd_op = 2'd0; end
      rdy("R10 insert dropped", 600, 1'b0);

      // R9: op table fill sweep
      squash(0);
      for (int k = 0; k < NO; k++) begin
         ins(2'b01, 100 + k, 0, st);
         check("R9 op slot available", 64'(st), 64'd0);
      end
      ins(2'b01, 100 + NO, 0, st);
      check("R9 op table full stalls", 64'(st), 64'd1);
      rdy("R9 stalled op absent", 100 + NO, 1'b0);
      for (int k = 0; k < NO; k++) rdy("R9 filled op ready", 100 + k, 1'b1);

      // R9: store table fill sweep
      squash(0);
      for (int k = 0; k < NS; k++) begin
         ins(2'b10, 200 + k, 0, st);
         check("R9 store slot available", 64'(st), 64'd0);
      end
      ins(2'b10, 200 + NS, 0, st);
      check("R9 store table full stalls", 64'(st), 64'd1);
      check("R9 stalled store not registered", 64'(pst_valid), 64'd0);
      ins(2'b01, 300, 0, st);
      check("R9 load still accepted", 64'(st), 64'd0);

      // R9: dependent list fill sweep
      squash(0);
      ins(2'b10, 400, 0, st);
      for (int k = 1; k <= ND; k++) begin
         ins(2'b01, 400 + k, 400, st);
         check("R9 dependent room", 64'(st), 64'd0);
      end
      ins(2'b01, 401 + ND, 400, st);
      check("R9 full dependent list stalls", 64'(st), 64'd1);
      wake(400);
      for (int k = 1; k <= ND; k++) rdy("R5 every listed dependent released", 400 + k, 1'b1);
      rdy("R9 stalled dependent absent", 401 + ND, 1'b0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule